// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Committed Divider Settings

This block produces one pulse-width modulated output per channel from a common reference clock. Each channel divides the reference clock in two cascaded stages. A prescaler turns reference cycles into ticks, and a period divider counts ticks into a period. A high-duration count, compared against the tick position, sets how long the output stays high at the start of each period. Software reaches the channels through a small memory-mapped register bus with single-cycle writes and combinational reads.

The three counts that software writes are held in shadow registers. They reach the running waveform only when software raises the update flag. While the channel runs, the transfer waits for the end of the current period. While the channel is stopped, it happens at once. A waveform in progress therefore never runs with a mix of old and new settings. The enable flag starts and stops a channel directly. A stopped channel drives low and restarts from the first tick of a fresh period.

Top module: `pwm_multi`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared and every register clears to zero; after reset all outputs are low and every register reads 0.
- R2: Channel c, register r (r = 0 or 1) sits at byte address (c*2 + r)*4, and address bits [1:0] are ignored. Register 0 holds the period divider in bits [15:0] and the high count in bits [31:16]. Register 1 holds the prescaler in bits [15:0], enable in bit 31 and update in bit 30. Bits [29:16] of register 1 read 0. Reads return the shadow contents.
- R3: With prescaler P, divider D and high count H active and H <= D+1, the output repeats with a period of (P+1)*(D+1) clock cycles. It is high for the first H*(P+1) cycles of each period and low for the rest.
- R4: A high count of 0 gives a constant low output. A high count of D+1 or more gives a constant high output.
- R5: A write to register 0 without a later update does not change the running waveform.
- R6: When update is set on a running channel, the period in progress completes with the old settings. The new settings apply from the next period onward.
- R7: The update flag reads 1 from the write that sets it until the settings are transferred, and reads 0 after that.
- R8: When update is set on a stopped channel, the transfer happens on the next clock edge. A later enable with no update then runs with those settings.
- R9: In the cycle after the edge that writes enable = 1, the output is still low. From the next edge on, the first period starts at tick 0. After the edge that writes enable = 0, the output follows the waveform for one more cycle and then stays low.
- R10: Writes to one channel leave the waveform and the register contents of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address; 0 when no read is selected |
| pwm_out | output | NCH (4) | One waveform output per channel |

## Verification
The bench builds the block with its default of four channels and 16-bit count fields. It programs only small prescaler and divider values, so every period boundary, the transfer held back at the boundary and the constant-high and constant-low cases can be checked sample by sample within a few hundred cycles. With all four channels present, it can run one channel while writing to another and show that neither disturbs the other.

// File: rtl/pwm_pkg.sv
// Package pwm_pkg
// Shared field layout and configuration type for the pulse-width modulator.
// Assumes 32-bit bus words and 16-bit count fields.
package pwm_pkg;
    localparam int DATA_W    = 32;
    localparam int FIELD_W   = 16;
    localparam int HI_LSB    = 16;
    localparam int EN_BIT    = 31;
    localparam int UPD_BIT   = 30;
    localparam int REG_BYTES = 4;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t pre;
        field_t div;
        field_t hi;
    } chan_cfg_t;

    // Builds the read word of the divider/high register.
    function automatic logic [DATA_W-1:0] pack_period(field_t div, field_t hi);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FIELD_W-1:0] = div;
        w[HI_LSB +: FIELD_W] = hi;
        return w;
    endfunction

    // Builds the read word of the control/prescaler register.
    function automatic logic [DATA_W-1:0] pack_ctrl(field_t pre, logic en, logic upd);
        logic [DATA_W-1:0] w;
        w = '0;
        w[FIELD_W-1:0] = pre;
        w[EN_BIT] = en;
        w[UPD_BIT] = upd;
        return w;
    endfunction
endpackage

// File: rtl/pwm_regfile.sv
// Module pwm_regfile
// Holds the shadow settings, the enable flags and the pending-update flags
// of every channel, and decodes single-cycle bus writes and combinational reads.
// Assumes byte addresses: bits [1:0] are ignored, bit 2 selects the register
// and the bits above it select the channel.
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CH_W   = 2,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [NCH-1:0]        commit,
    output logic [DATA_W-1:0]     bus_rdata,
    output chan_cfg_t [NCH-1:0]   shadow_cfg,
    output logic [NCH-1:0]        enable,
    output logic [NCH-1:0]        pending
);
    logic [CH_W-1:0] sel_ch;
    logic            sel_ctrl;
    logic            addr_unused;

    assign sel_ch      = bus_addr[ADDR_W-1:3];
    assign sel_ctrl    = bus_addr[2];
    assign addr_unused = ^bus_addr[1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_cfg_t cfg_r;
        logic      en_r;
        logic      pend_r;
        logic      hit;

        assign hit = bus_sel && bus_we && (sel_ch == CH_W'(c));

        // Captures the shadow fields and enable flag on a write to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r <= '0;
                en_r  <= 1'b0;
            end else if (hit && !sel_ctrl) begin
                cfg_r.div <= bus_wdata[FIELD_W-1:0];
                cfg_r.hi  <= bus_wdata[HI_LSB +: FIELD_W];
            end else if (hit && sel_ctrl) begin
                cfg_r.pre <= bus_wdata[FIELD_W-1:0];
                en_r      <= bus_wdata[EN_BIT];
            end
        end

        // Sets the pending flag on an update write and clears it on transfer; a set wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_r <= 1'b0;
            end else if (hit && sel_ctrl && bus_wdata[UPD_BIT]) begin
                pend_r <= 1'b1;
            end else if (commit[c]) begin
                pend_r <= 1'b0;
            end
        end

        assign shadow_cfg[c] = cfg_r;
        assign enable[c]     = en_r;
        assign pending[c]    = pend_r;
    end

    // Returns the shadow contents of the addressed register on a read.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bus_sel && !bus_we && (sel_ch == CH_W'(c))) begin
                bus_rdata = sel_ctrl ? pack_ctrl(shadow_cfg[c].pre, enable[c], pending[c])
                                     : pack_period(shadow_cfg[c].div, shadow_cfg[c].hi);
            end
        end
    end
endmodule

// File: rtl/pwm_channel.sv
// Module pwm_channel
// One waveform generator: the active settings, a prescale counter feeding a
// period counter, and the compare that forms the output.
// Assumes the enable and pending inputs come from registers. The running flag
// follows enable one cycle later, so a channel that is started begins from
// reset counters. Pending settings are taken on the last cycle of a period,
// or at once while the channel is not running.
module pwm_channel
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t shadow_cfg,
    input  logic      enable,
    input  logic      pending,
    output logic      commit,
    output logic      running,
    output chan_cfg_t active_cfg,
    output logic      wave_out
);
    field_t pre_cnt;
    field_t per_cnt;
    logic   pre_last;
    logic   per_last;

    assign pre_last = (pre_cnt == active_cfg.pre);
    assign per_last = (per_cnt == active_cfg.div);
    assign commit   = pending && (!running || (pre_last && per_last));

    // Delays enable by one cycle to give the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= enable;
    end

    // Loads the active settings from the shadow copy on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      active_cfg <= '0;
        else if (commit) active_cfg <= shadow_cfg;
    end

    // Advances the prescale and period counters, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (pre_last) begin
            pre_cnt <= '0;
            per_cnt <= per_last ? '0 : per_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign wave_out = running && (per_cnt < active_cfg.hi);
endmodule

// File: rtl/pwm_multi.sv
// Module pwm_multi
// Top of the multi-channel pulse-width modulator: one register file and
// NCH waveform generators that share the reference clock.
// Assumes a synchronous active-low reset and single-cycle bus accesses.
module pwm_multi
    import pwm_pkg::*;
#(
    parameter  int NCH    = 4,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W = CH_W + $clog2(2 * REG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    chan_cfg_t [NCH-1:0] shadow_vec;
    chan_cfg_t [NCH-1:0] act_vec;
    logic [NCH-1:0]      en_vec;
    logic [NCH-1:0]      pend_vec;
    logic [NCH-1:0]      commit_vec;
    logic [NCH-1:0]      run_vec;

    pwm_regfile #(
        .NCH    (NCH),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .commit     (commit_vec),
        .bus_rdata  (bus_rdata),
        .shadow_cfg (shadow_vec),
        .enable     (en_vec),
        .pending    (pend_vec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .shadow_cfg (shadow_vec[c]),
            .enable     (en_vec[c]),
            .pending    (pend_vec[c]),
            .commit     (commit_vec[c]),
            .running    (run_vec[c]),
            .active_cfg (act_vec[c]),
            .wave_out   (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_multi_chk.sv
// Module pwm_multi_chk
// Temporal checks on the pulse-width modulator, attached to every instance of
// pwm_multi by the bind below.
module pwm_multi_chk
    import pwm_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCH-1:0]      pwm_out,
    input logic [NCH-1:0]      en_vec,
    input logic [NCH-1:0]      pend_vec,
    input logic [NCH-1:0]      commit_vec,
    input chan_cfg_t [NCH-1:0] act_vec
);
    assert_reset_clears_R1: assert property (@(posedge clk) !rst_n |=> (pwm_out == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_stopped_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_vec[c] && $past(!en_vec[c])) |-> !pwm_out[c]);

        assert_pend_clears_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_vec[c]) |-> $past(commit_vec[c]));

        assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !commit_vec[c] |=> $stable(act_vec[c]));

        assert_zero_high_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (act_vec[c].hi == '0) |-> !pwm_out[c]);

        assert_idle_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_vec[c] && !en_vec[c] && $past(!en_vec[c])) |-> commit_vec[c]);
    end
endmodule

bind pwm_multi pwm_multi_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_out    (pwm_out),
    .en_vec     (en_vec),
    .pend_vec   (pend_vec),
    .commit_vec (commit_vec),
    .act_vec    (act_vec)
);

// File: tb/pwm_multi_test.sv
// Scoreboard bench for pwm_multi: driver code pushes the expected output bit of
// one channel per cycle into a queue, and a monitor pops and compares one
// entry at every falling edge.
module pwm_multi_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] UPD = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    typedef struct {
        int    ch;
        bit    val;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    pwm_multi #(.NCH(NCH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Monitor: compares one expected output bit per cycle.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (pwm_out[e.ch] !== e.val) begin
                n_fail++;
                $display("FAIL %s: ch%0d output actual %0b expected %0b at %0t",
                         e.req, e.ch, pwm_out[e.ch], e.val, $time);
            end
        end
    end

    task automatic push(input int ch, input bit val, input string req);
        exp_t e;
        e.ch = ch; e.val = val; e.req = req;
        q.push_back(e);
    endtask

    task automatic push_wave(input int ch, input int pre, input int div, input int hi,
                             input int nper, input string req);
        for (int p = 0; p < nper; p++) begin
            for (int k = 0; k < (pre + 1) * (div + 1); k++) begin
                push(ch, (k / (pre + 1)) < hi, req);
            end
        end
    endtask

    task automatic drive(input int ch, input int r, input logic [31:0] data);
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = 5'((ch * 2 + r) * 4);
        bus_wdata = data;
    endtask

    task automatic release_bus();
        bus_sel = 1'b0;
        bus_we  = 1'b0;
    endtask

    task automatic wr(input int ch, input int r, input logic [31:0] data);
        drive(ch, r, data);
        @(posedge clk);
        @(negedge clk);
        release_bus();
    endtask

    task automatic rd_check(input int ch, input int r, input logic [31:0] exp, input string req);
        bus_sel  = 1'b1;
        bus_we   = 1'b0;
        bus_addr = 5'((ch * 2 + r) * 4);
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: read ch%0d reg%0d actual %h expected %h", req, ch, r, bus_rdata, exp);
        end
        bus_sel = 1'b0;
    endtask

    task automatic out_check(input int ch, input bit exp, input string req);
        n_chk++;
        if (pwm_out[ch] !== exp) begin
            n_fail++;
            $display("FAIL %s: ch%0d output actual %0b expected %0b", req, ch, pwm_out[ch], exp);
        end
    endtask

    task automatic drain();
        wait (q.size() == 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCH; c++) out_check(c, 1'b0, "R1");
        for (int c = 0; c < NCH; c++) begin
            rd_check(c, 0, 32'h0, "R1");
            rd_check(c, 1, 32'h0, "R1");
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: address map, field placement and unused control bits
        for (int c = 0; c < NCH; c++) begin
            wr(c, 0, {16'(c * 16 + 7), 16'(c + 3)});
            wr(c, 1, 32'h3FFF_0000 | 32'(c + 9));
        end
        for (int c = 0; c < NCH; c++) begin
            rd_check(c, 0, {16'(c * 16 + 7), 16'(c + 3)}, "R2");
            rd_check(c, 1, 32'(c + 9), "R2");
            out_check(c, 1'b0, "R2");
        end

        // R3 and R9: channel 0, no prescale, divider 3, high 1
        wr(0, 0, {16'd1, 16'd3});
        drive(0, 1, EN | UPD);
        @(posedge clk);
        push(0, 1'b0, "R9");
        push_wave(0, 0, 3, 1, 3, "R3");
        @(negedge clk);
        release_bus();
        drain();

        // R9: stopping channel 0 at a period start
        drive(0, 1, UPD);
        @(posedge clk);
        push(0, 1'b1, "R9");
        for (int i = 0; i < 4; i++) push(0, 1'b0, "R9");
        @(negedge clk);
        release_bus();
        drain();
        rd_check(0, 1, 32'h0, "R7");

        // R3 with prescale on channel 1; R10 and R8 on channel 2 while channel 1 runs
        wr(1, 0, {16'd2, 16'd4});
        drive(1, 1, EN | UPD | 32'd2);
        @(posedge clk);
        push(1, 1'b0, "R9");
        push_wave(1, 2, 4, 2, 3, "R3");
        @(negedge clk);
        release_bus();
        wr(2, 0, {16'd5, 16'd2});
        wr(2, 1, UPD | 32'd1);
        @(negedge clk);
        rd_check(2, 1, 32'h1, "R8");
        rd_check(0, 0, {16'd1, 16'd3}, "R10");
        out_check(0, 1'b0, "R10");
        out_check(2, 1'b0, "R8");
        drain();

        // R8 and R4: enable without update uses the settings taken while stopped
        drive(2, 1, EN | 32'd1);
        @(posedge clk);
        push(2, 1'b0, "R9");
        push_wave(2, 1, 2, 5, 2, "R4");
        @(negedge clk);
        release_bus();
        drain();

        // R4: high count of zero gives a constant low output
        wr(2, 1, 32'd1);
        repeat (3) @(negedge clk);
        out_check(2, 1'b0, "R9");
        wr(2, 0, {16'd0, 16'd2});
        drive(2, 1, EN | UPD | 32'd1);
        @(posedge clk);
        push(2, 1'b0, "R9");
        push_wave(2, 1, 2, 0, 2, "R4");
        @(negedge clk);
        release_bus();
        drain();

        // R5, R6, R7: settings change on channel 3 held back to the period boundary
        wr(3, 0, {16'd4, 16'd7});
        drive(3, 1, EN | UPD);
        @(posedge clk);
        push(3, 1'b0, "R9");
        push_wave(3, 0, 7, 4, 1, "R5");
        push_wave(3, 0, 3, 1, 2, "R6");
        @(negedge clk);
        release_bus();
        @(negedge clk);
        @(negedge clk);
        wr(3, 0, {16'd1, 16'd3});
        wr(3, 1, EN | UPD);
        @(negedge clk);
        rd_check(3, 1, EN | UPD, "R7");
        rd_check(3, 0, {16'd1, 16'd3}, "R2");
        drain();
        rd_check(3, 1, EN, "R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule